// File: doc/BRIEF.md
# Leveled Vectored Interrupt Controller

This block gathers single-cycle request pulses from a set of peripheral sources and turns them into one prioritised interrupt request for a CPU core. Every source owns a sticky pending flag, a mask bit and a three-bit priority level. Each cycle the controller looks at every source that is both pending and unmasked and picks the one with the highest level. It raises its request to the core only when that level is strictly above the core's current running level, the core's global enable is set and no higher-precedence inhibit is present.

Together with the request, the block presents a vector number and the address of that vector's entry in the vector table. Software reaches the flags, masks and levels through a small register port. Flags are cleared by writing ones. One source is reserved for a serial port. Its receive-error pulse is produced inside the block from three error conditions, gated by a receive-error enable.

Top module: `lvic_top`

## Requirements
- R1: A one-cycle pulse on a source input sets that source's flag at the next clock edge. The flag stays set until software clears it. Flags read at register address 0, with bit i for source i.
- R2: A pulse sets the flag even when the source's mask bit (register address 1, bit i) is 0.
- R3: A request is raised only for a source whose flag and mask bit are both 1. Clearing the mask bit withdraws the request.
- R4: Each source has a 3-bit level, 0 to 7. The levels are held at register address 2, with source i at bits [3i+2:3i]. They read back as written.
- R5: A request is raised only while `core_ie` is 1 and the winning level is strictly greater than `core_il`. An equal level gives no request.
- R6: While `hp_inhibit` is 1, no request is raised.
- R7: The vector number is VEC_BASE (default 12) plus the source index. The address is TABLE_BASE (default 0x8000) plus four times the vector number. The serial source (index 4) therefore yields vector 16 at address 0x8040.
- R8: The serial source's flag is set by a parity, framing or overrun error only while `ser_rxerr_en` is 1. With the enable at 0, these errors leave the flag unchanged.
- R9: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. If a pulse arrives in the same cycle as the clear, the flag stays set.
- R10: Among pending unmasked sources, the highest level wins. On a tie, the lowest source index wins.
- R11: `irq_req`, `irq_vec` and `irq_addr` are registered. They change one clock edge after the flag, mask, level or core input that caused the change. While `irq_req` is 0, `irq_vec` and `irq_addr` are 0.
- R12: After reset, all flags, masks and levels are 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_pulse | input | NUM_SRC | One-cycle request pulse for each source |
| ser_rxerr_en | input | 1 | Receive-error enable for the serial source |
| ser_par_err | input | 1 | Serial parity error condition |
| ser_frm_err | input | 1 | Serial framing error condition |
| ser_ovr_err | input | 1 | Serial overrun error condition |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 flags, 1 masks, 2 levels |
| reg_wdata | input | 3*NUM_SRC | Register write data |
| reg_rdata | output | 3*NUM_SRC | Register read data for the selected address |
| core_ie | input | 1 | Core global interrupt enable |
| core_il | input | 3 | Core current interrupt level |
| hp_inhibit | input | 1 | Higher-precedence condition present |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector number of the requesting source |
| irq_addr | output | ADDR_W | Vector-table entry address |

## Verification
The bench pulses a masked source and reads the flag register to separate latching from masking. It then sweeps `core_il` below, equal to and above the winning level, and toggles `core_ie` and `hp_inhibit`, which separates a strict comparison from a loose one. Two pending sources are given different levels and then equal levels, which shows whether the arbiter ranks by level and breaks ties by index. Each serial error condition is applied with the receive-error enable off and on. A clear is also made to coincide with a new pulse, so that a lost event would show.

// File: rtl/lvic_pkg.sv
package lvic_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef enum logic [1:0] {
    RA_FLAG = 2'd0,
    RA_MASK = 2'd1,
    RA_LVL  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/lvic_rst_sync.sv
module lvic_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_s_n = sh_q[1];
endmodule

// File: rtl/lvic_rxerr.sv
module lvic_rxerr (
  input  logic rxerr_en,
  input  logic par_err,
  input  logic frm_err,
  input  logic ovr_err,
  output logic err_pulse
);
  // any of the three error conditions, gated by the enable
  assign err_pulse = rxerr_en & (par_err | frm_err | ovr_err);
endmodule

// File: rtl/lvic_regs.sv
module lvic_regs
  import lvic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int RW = NUM_SRC * LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_pulse,
  input  logic               we,
  input  logic [1:0]         addr,
  input  logic [RW-1:0]      wdata,
  output logic [RW-1:0]      rdata,
  output logic [NUM_SRC-1:0] flags_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [RW-1:0]      lvl_o
);
  logic [NUM_SRC-1:0] flag_q, flag_d, clr;
  logic [NUM_SRC-1:0] mask_q;
  logic [RW-1:0]      lvl_q;
  logic               mask_ld, lvl_ld;

  // next-state
  always_comb begin
    clr     = (we && addr == RA_FLAG) ? wdata[NUM_SRC-1:0] : '0;
    flag_d  = (flag_q & ~clr) | set_pulse;   // new pulse beats a clear
    mask_ld = we && (addr == RA_MASK);
    lvl_ld  = we && (addr == RA_LVL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      lvl_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (mask_ld) mask_q <= wdata[NUM_SRC-1:0];
      if (lvl_ld)  lvl_q  <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_FLAG: rdata[NUM_SRC-1:0] = flag_q;
      RA_MASK: rdata[NUM_SRC-1:0] = mask_q;
      RA_LVL:  rdata              = lvl_q;
      default: rdata              = '0;
    endcase
  end

  assign flags_o = flag_q;
  assign mask_o  = mask_q;
  assign lvl_o   = lvl_q;
endmodule

// File: rtl/lvic_arb.sv
module lvic_arb
  import lvic_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int RW    = NUM_SRC * LVL_W
) (
  input  logic [NUM_SRC-1:0] cand,
  input  logic [RW-1:0]      lvl_flat,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_t               win_lvl
);
  lvl_t lvl_arr [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_unpack
    assign lvl_arr[g] = lvl_flat[g*LVL_W +: LVL_W];
  end

  // ascending scan with a strict compare keeps the lowest index on a tie
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!win_valid || lvl_arr[i] > win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_lvl   = lvl_arr[i];
      end
    end
  end
endmodule

// File: rtl/lvic_top.sv
module lvic_top
  import lvic_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int VEC_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 12,
  parameter int TABLE_BASE = 32'h8000,
  parameter int SER_IDX    = 4,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int RW    = NUM_SRC * LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               ser_rxerr_en,
  input  logic               ser_par_err,
  input  logic               ser_frm_err,
  input  logic               ser_ovr_err,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [RW-1:0]      reg_wdata,
  output logic [RW-1:0]      reg_rdata,
  input  logic               core_ie,
  input  logic [LVL_W-1:0]   core_il,
  input  logic               hp_inhibit,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic [ADDR_W-1:0]  irq_addr
);
  logic               rst_s_n;
  logic               ser_err_pulse;
  logic [NUM_SRC-1:0] pulse_eff;
  logic [NUM_SRC-1:0] flags, masks;
  logic [RW-1:0]      lvls;
  logic               win_valid;
  logic [IDX_W-1:0]   win_idx;
  lvl_t               win_lvl;
  logic               accept;
  logic               req_q;
  logic [VEC_W-1:0]   vec_d, vec_q;
  logic [ADDR_W-1:0]  addr_d, addr_q;

  lvic_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  lvic_rxerr u_rxerr (
    .rxerr_en  (ser_rxerr_en),
    .par_err   (ser_par_err),
    .frm_err   (ser_frm_err),
    .ovr_err   (ser_ovr_err),
    .err_pulse (ser_err_pulse)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_pulse
    if (s == SER_IDX) begin : g_ser
      assign pulse_eff[s] = src_pulse[s] | ser_err_pulse;
    end else begin : g_plain
      assign pulse_eff[s] = src_pulse[s];
    end
  end

  lvic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .set_pulse (pulse_eff),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .flags_o   (flags),
    .mask_o    (masks),
    .lvl_o     (lvls)
  );

  lvic_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .cand      (flags & masks),
    .lvl_flat  (lvls),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_lvl   (win_lvl)
  );

  // next-state for the core-facing outputs
  always_comb begin
    accept = win_valid && core_ie && !hp_inhibit && (win_lvl > core_il);
    vec_d  = accept ? (VEC_W'(VEC_BASE) + VEC_W'(win_idx)) : '0;
    addr_d = accept ? (ADDR_W'(TABLE_BASE) + (ADDR_W'(vec_d) << 2)) : '0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      req_q  <= 1'b0;
      vec_q  <= '0;
      addr_q <= '0;
    end else begin
      req_q  <= accept;
      vec_q  <= vec_d;
      addr_q <= addr_d;
    end
  end

  assign irq_req  = req_q;
  assign irq_vec  = vec_q;
  assign irq_addr = addr_q;
endmodule

// File: rtl/lvic_chk.sv
module lvic_chk #(
  parameter int NUM_SRC    = 8,
  parameter int VEC_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int TABLE_BASE = 32'h8000,
  parameter int SER_IDX    = 4
) (
  input logic               clk,
  input logic               rst_s_n,
  input logic [NUM_SRC-1:0] pulse_eff,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] masks,
  input logic               ser_rxerr_en,
  input logic               ser_par_err,
  input logic               ser_frm_err,
  input logic               ser_ovr_err,
  input logic               core_ie,
  input logic [2:0]         core_il,
  input logic               hp_inhibit,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vec,
  input logic [ADDR_W-1:0]  irq_addr
);
  // R1
  flag_latch_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|pulse_eff) |=> ((flags & $past(pulse_eff)) == $past(pulse_eff)));

  // R8
  rxerr_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ser_rxerr_en && (ser_par_err || ser_frm_err || ser_ovr_err)) |=> flags[SER_IDX]);

  // R3
  req_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_req |-> ($past(flags & masks) != '0));

  // R5
  req_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_req |-> ($past(core_ie) && ($past(core_il) != 3'd7)));

  // R6
  req_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_req |-> !$past(hp_inhibit));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !irq_req |-> (irq_vec == '0 && irq_addr == '0));

  // R7
  addr_map_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_req |-> (irq_addr == ADDR_W'(TABLE_BASE) + (ADDR_W'(irq_vec) << 2)));
endmodule

bind lvic_top lvic_chk #(
  .NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
  .TABLE_BASE(TABLE_BASE), .SER_IDX(SER_IDX)
) u_chk (
  .clk          (clk),
  .rst_s_n      (rst_s_n),
  .pulse_eff    (pulse_eff),
  .flags        (flags),
  .masks        (masks),
  .ser_rxerr_en (ser_rxerr_en),
  .ser_par_err  (ser_par_err),
  .ser_frm_err  (ser_frm_err),
  .ser_ovr_err  (ser_ovr_err),
  .core_ie      (core_ie),
  .core_il      (core_il),
  .hp_inhibit   (hp_inhibit),
  .irq_req      (irq_req),
  .irq_vec      (irq_vec),
  .irq_addr     (irq_addr)
);

// File: tb/sim_lvic_top.sv
module sim_lvic_top;
  localparam int N  = 8;
  localparam int RW = N * 3;
  localparam int VB = 12;
  localparam int TB = 32'h8000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src_pulse;
  logic          ser_rxerr_en, ser_par_err, ser_frm_err, ser_ovr_err;
  logic          reg_we;
  logic [1:0]    reg_addr;
  logic [RW-1:0] reg_wdata, reg_rdata;
  logic          core_ie;
  logic [2:0]    core_il;
  logic          hp_inhibit;
  logic          irq_req;
  logic [7:0]    irq_vec;
  logic [15:0]   irq_addr;

  int checks = 0;
  int errors = 0;
  logic [2:0] lvl_sh [N];

  always #4 clk = ~clk;

  lvic_top u0 (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .ser_rxerr_en(ser_rxerr_en), .ser_par_err(ser_par_err),
    .ser_frm_err(ser_frm_err), .ser_ovr_err(ser_ovr_err),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .core_ie(core_ie), .core_il(core_il),
    .hp_inhibit(hp_inhibit), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_addr(irq_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [RW-1:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    src_pulse = m;
    step();
    src_pulse = '0;
  endtask

  function automatic logic [RW-1:0] pack_lvls();
    logic [RW-1:0] p = '0;
    for (int i = 0; i < N; i++) p[i*3 +: 3] = lvl_sh[i];
    return p;
  endfunction

  function automatic logic [31:0] exp_vec(input int idx);
    return 32'(VB + idx);
  endfunction

  function automatic logic [31:0] exp_addr(input int idx);
    return 32'(TB + 4 * (VB + idx));
  endfunction

  task automatic t_reset();
    logic [RW-1:0] d;
    chk("R12 req after reset", irq_req, 0);
    chk("R12 vec after reset", irq_vec, 0);
    chk("R12 addr after reset", irq_addr, 0);
    rd(2'd0, d); chk("R12 flags after reset", d, 0);
    rd(2'd1, d); chk("R12 masks after reset", d, 0);
    rd(2'd2, d); chk("R12 levels after reset", d, 0);
  endtask

  task automatic t_masked_flag();
    logic [RW-1:0] d;
    core_ie = 1'b1; core_il = 3'd0;
    pulse(8'h04);
    rd(2'd0, d); chk("R1 R2 flag set while masked", d, 32'h04);
    step(); step();
    chk("R3 no req while masked", irq_req, 0);
    rd(2'd0, d); chk("R1 flag sticky", d, 32'h04);
  endtask

  task automatic t_accept();
    lvl_sh[2] = 3'd5;
    wr(2'd2, pack_lvls());
    wr(2'd1, 8'h04);
    chk("R11 req not yet one edge after mask write", irq_req, 0);
    step();
    chk("R3 req with flag and mask", irq_req, 1);
    chk("R7 vector of source 2", irq_vec, exp_vec(2));
    chk("R7 address of source 2", irq_addr, exp_addr(2));
    wr(2'd1, 8'h00);
    step();
    chk("R3 mask clear withdraws req", irq_req, 0);
    chk("R11 vec zero when idle", irq_vec, 0);
    wr(2'd1, 8'h04);
    step();
  endtask

  task automatic t_levels();
    core_il = 3'd4; step();
    chk("R5 level 5 over core 4", irq_req, 1);
    core_il = 3'd5; step();
    chk("R5 equal level refused", irq_req, 0);
    core_il = 3'd6; step();
    chk("R5 lower level refused", irq_req, 0);
    core_il = 3'd4; core_ie = 1'b0; step();
    chk("R5 global enable off", irq_req, 0);
    core_ie = 1'b1; hp_inhibit = 1'b1; step();
    chk("R6 inhibit blocks", irq_req, 0);
    hp_inhibit = 1'b0; step();
    chk("R6 inhibit released", irq_req, 1);
    core_il = 3'd0;
  endtask

  task automatic t_priority();
    logic [RW-1:0] d;
    wr(2'd0, '1);
    pulse(8'h42);
    lvl_sh[1] = 3'd3; lvl_sh[6] = 3'd6;
    wr(2'd2, pack_lvls());
    rd(2'd2, d); chk("R4 level readback", d, pack_lvls());
    wr(2'd1, 8'h42);
    step();
    chk("R10 higher level wins", irq_vec, exp_vec(6));
    lvl_sh[1] = 3'd6;
    wr(2'd2, pack_lvls());
    step();
    chk("R10 tie goes to lower index", irq_vec, exp_vec(1));
    chk("R10 tie address", irq_addr, exp_addr(1));
  endtask

  task automatic t_w1c();
    logic [RW-1:0] d;
    wr(2'd0, 8'h02);
    rd(2'd0, d); chk("R9 write one clears only that flag", d, 32'h40);
    step();
    chk("R9 remaining source requests", irq_vec, exp_vec(6));
    src_pulse = 8'h40;
    wr(2'd0, 8'h40);
    src_pulse = '0;
    rd(2'd0, d); chk("R9 pulse beats clear", d, 32'h40);
  endtask

  task automatic t_serial();
    logic [RW-1:0] d;
    wr(2'd0, '1);
    for (int i = 0; i < N; i++) lvl_sh[i] = 3'd0;
    lvl_sh[4] = 3'd7;
    wr(2'd2, pack_lvls());
    wr(2'd1, 8'h10);
    ser_rxerr_en = 1'b0;
    ser_par_err = 1'b1; ser_frm_err = 1'b1; ser_ovr_err = 1'b1; step();
    ser_par_err = 1'b0; ser_frm_err = 1'b0; ser_ovr_err = 1'b0;
    rd(2'd0, d); chk("R8 errors ignored while disabled", d, 0);
    step();
    chk("R8 no req while disabled", irq_req, 0);
    ser_rxerr_en = 1'b1;
    ser_frm_err = 1'b1; step(); ser_frm_err = 1'b0;
    rd(2'd0, d); chk("R8 framing error sets flag", d, 32'h10);
    step();
    chk("R7 serial vector 16", irq_vec, 32'd16);
    chk("R7 serial address 0x8040", irq_addr, 32'h8040);
    wr(2'd0, 8'h10);
    ser_ovr_err = 1'b1; step(); ser_ovr_err = 1'b0;
    rd(2'd0, d); chk("R8 overrun sets flag", d, 32'h10);
    wr(2'd0, 8'h10);
    ser_par_err = 1'b1; step(); ser_par_err = 1'b0;
    rd(2'd0, d); chk("R8 parity sets flag", d, 32'h10);
    ser_rxerr_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) lvl_sh[i] = 3'd0;
    rst_n = 1'b0; src_pulse = '0;
    ser_rxerr_en = 1'b0; ser_par_err = 1'b0; ser_frm_err = 1'b0; ser_ovr_err = 1'b0;
    reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    core_ie = 1'b0; core_il = 3'd0; hp_inhibit = 1'b0;
    repeat (4) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_masked_flag();
    t_accept();
    t_levels();
    t_priority();
    t_w1c();
    t_serial();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule